// File: doc/BRIEF.md
# Scan Vector Serializer with Test-Clock Counter

This block turns parallel test vectors into a serial boundary-scan stream. A processor or a vector memory writes paired words, one carrying TDI bits and one carrying TMS bits. The block shifts them out one bit per test clock. On every clock it also captures the returned TDO bit and packs these bits into words that the host reads back. All three streams pass through buffers, so the host can keep refilling and draining them while an operation runs.

The length of an operation is set by a cycle count loaded at start. The count can be as wide as 32 bits, so the same mechanism times a long built-in self-test run as well as a short scan. The test clock runs at half the system clock: with a 50 MHz system clock it reaches 25 MHz. If the input buffer runs dry, or the capture path has no room, the test clock stops low until data or space appears. A select input routes the generated signals to the backplane test bus or to an external header. The port that is not selected rests at fixed idle levels.

Top module: `scan_serializer`

## Requirements
- R1: After reset, busy and done are low, both TCK outputs are low, out_valid is low and in_ready is high.
- R2: TDI and TMS bits leave least significant bit first, one bit per TCK pulse. Pulse k of an operation carries bit k mod W of the (k div W)-th written pair: bits [W-1:0] of in_tdi and of in_tms from the same write.
- R3: On every TCK pulse the selected TDO input is captured. Captured bits are packed least significant bit first into W-bit words on out_data. A final partial word is delivered with its unused upper bits at zero, and no other word is produced.
- R4: An operation issues exactly start_count TCK pulses. A count of zero issues none and raises done one clock after start. TCK is low whenever busy is low.
- R5: busy is high from the clock after an accepted start until the operation completes. done is high from completion until the next accepted start. The two are never high together. A start while busy is ignored.
- R6: Each TCK high phase lasts exactly one system clock. TDI and TMS change only at the falling edge of TCK and are stable while TCK is high.
- R7: While the current input word is used up and no new pair is buffered, TCK stays low and busy stays high. Shifting resumes when a pair is written.
- R8: When the output buffer is full and the capture shifter holds W bits, TCK stays low. At that point exactly W*(DEPTH+1) pulses have occurred, and no captured bit is lost. A held output word stays valid and unchanged until it is read.
- R9: sel_ext=0 drives the backplane pins and takes TDO from bp_tdo. sel_ext=1 drives the external pins and takes TDO from ext_tdo. The unselected port holds TCK=0, TMS=1, TDI=1 and gives no pulses.
- R10: Bits left unused in a partly consumed input word are discarded when the next operation starts. Each operation begins with a freshly written pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; TCK is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when not busy |
| start_count | input | CNT_W | Number of TCK pulses for the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation complete |
| sel_ext | input | 1 | 0: backplane port, 1: external header |
| in_valid | input | 1 | Vector pair offered |
| in_ready | output | 1 | Input buffer has room |
| in_tdi | input | W | TDI bits of the pair |
| in_tms | input | W | TMS bits of the pair |
| out_valid | output | 1 | Captured TDO word available |
| out_ready | input | 1 | Host takes the word |
| out_data | output | W | Captured TDO word |
| bp_tck | output | 1 | Backplane test clock |
| bp_tms | output | 1 | Backplane mode select |
| bp_tdi | output | 1 | Backplane data out |
| bp_tdo | input | 1 | Backplane data in |
| ext_tck | output | 1 | Header test clock |
| ext_tms | output | 1 | Header mode select |
| ext_tdi | output | 1 | Header data out |
| ext_tdo | input | 1 | Header data in |

## Verification
The assertions assume that sel_ext changes only while no operation is running, because the pin steering and the idle-level checks read the select as steady during a run. The bench changes the route only between operations, after done is seen. Each input pair is held on the bus until it is accepted. TDO is changed only after a falling TCK on the selected port, which matches the sampling point the block expects of a scan target.

// File: rtl/scan_ser_pkg.sv
package scan_ser_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2,
      ST_DONE  = 2'd3
   } eng_state_t;

   // levels held by an unselected scan port
   localparam logic REST_TCK = 1'b0;
   localparam logic REST_TMS = 1'b1;
   localparam logic REST_TDI = 1'b1;

endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   input  logic          rd_ready
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("scan_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   fill_q;
   logic          push, pop;

   always_comb begin
      wr_ready = (fill_q != (AW+1)'(DEPTH));
      rd_valid = (fill_q != '0);
      rd_data  = mem_q[rp_q];
      push     = wr_valid && wr_ready;
      pop      = rd_valid && rd_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
      end else begin
         if (push) begin
            mem_q[wp_q] <= wr_data;
            wp_q        <= wp_q + AW'(1);
         end
         if (pop) rp_q <= rp_q + AW'(1);
         case ({push, pop})
            2'b10:   fill_q <= fill_q + (AW+1)'(1);
            2'b01:   fill_q <= fill_q - (AW+1)'(1);
            default: fill_q <= fill_q;
         endcase
      end
   end
endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine
   import scan_ser_pkg::*;
#(
   parameter int W     = 8,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_count,
   input  logic             src_valid,
   input  logic [W-1:0]     src_tdi,
   input  logic [W-1:0]     src_tms,
   output logic             src_pop,
   output logic             snk_push,
   output logic [W-1:0]     snk_data,
   input  logic             snk_ready,
   input  logic             tdo_in,
   output logic             tck,
   output logic             tms,
   output logic             tdi,
   output logic             busy,
   output logic             done
);
   localparam int BW = $clog2(W + 1);

   eng_state_t       st_q;
   logic [CNT_W-1:0] remain_q;
   logic             tck_q;
   logic [W-1:0]     tdi_sr_q, tms_sr_q, tdo_sr_q;
   logic [BW-1:0]    in_left_q, out_fill_q;

   logic running, in_empty, out_full, accept, load, rise, fall, drain;
   logic [W-1:0] cap_mask;

   always_comb begin
      running  = (st_q == ST_RUN);
      in_empty = (in_left_q == '0);
      out_full = (out_fill_q == BW'(W));
      accept   = start && (st_q == ST_IDLE || st_q == ST_DONE);
      load     = running && in_empty && src_valid;
      rise     = running && !tck_q && !in_empty && !out_full;
      fall     = tck_q;
      drain    = snk_ready && ((running && out_full) ||
                               (st_q == ST_FLUSH && out_fill_q != '0));
      cap_mask = {{(W-1){1'b0}}, tdo_in} << out_fill_q;
      src_pop  = load;
      snk_push = drain;
      snk_data = tdo_sr_q;
      tck      = tck_q;
      tdi      = tdi_sr_q[0];
      tms      = tms_sr_q[0];
      busy     = running || (st_q == ST_FLUSH);
      done     = (st_q == ST_DONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         remain_q   <= '0;
         tck_q      <= 1'b0;
         tdi_sr_q   <= '0;
         tms_sr_q   <= '0;
         tdo_sr_q   <= '0;
         in_left_q  <= '0;
         out_fill_q <= '0;
      end else if (accept) begin
         st_q       <= (start_count == '0) ? ST_DONE : ST_RUN;
         remain_q   <= start_count;
         tck_q      <= 1'b0;
         tdo_sr_q   <= '0;
         in_left_q  <= '0;
         out_fill_q <= '0;
      end else begin
         if (load) begin
            tdi_sr_q  <= src_tdi;
            tms_sr_q  <= src_tms;
            in_left_q <= BW'(W);
         end
         if (rise) tck_q <= 1'b1;
         if (fall) begin
            tck_q      <= 1'b0;
            tdi_sr_q   <= tdi_sr_q >> 1;
            tms_sr_q   <= tms_sr_q >> 1;
            in_left_q  <= in_left_q - BW'(1);
            remain_q   <= remain_q - CNT_W'(1);
            tdo_sr_q   <= tdo_sr_q | cap_mask;
            out_fill_q <= out_fill_q + BW'(1);
            if (remain_q == CNT_W'(1)) st_q <= ST_FLUSH;
         end
         if (drain) begin
            tdo_sr_q   <= '0;
            out_fill_q <= '0;
            if (st_q == ST_FLUSH) st_q <= ST_DONE;
         end
         if (st_q == ST_FLUSH && out_fill_q == '0) st_q <= ST_DONE;
      end
   end
endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux
   import scan_ser_pkg::*;
#(
   parameter bit EXT_EN = 1'b1
) (
   input  logic sel_ext,
   input  logic tck,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic bp_tck,
   output logic bp_tms,
   output logic bp_tdi,
   input  logic bp_tdo,
   output logic ext_tck,
   output logic ext_tms,
   output logic ext_tdi,
   input  logic ext_tdo
);
   generate
      if (EXT_EN) begin : g_two_ports
         always_comb begin
            bp_tck  = sel_ext ? REST_TCK : tck;
            bp_tms  = sel_ext ? REST_TMS : tms;
            bp_tdi  = sel_ext ? REST_TDI : tdi;
            ext_tck = sel_ext ? tck : REST_TCK;
            ext_tms = sel_ext ? tms : REST_TMS;
            ext_tdi = sel_ext ? tdi : REST_TDI;
            tdo     = sel_ext ? ext_tdo : bp_tdo;
         end
      end else begin : g_bp_only
         always_comb begin
            bp_tck  = tck;
            bp_tms  = tms;
            bp_tdi  = tdi;
            ext_tck = REST_TCK;
            ext_tms = REST_TMS;
            ext_tdi = REST_TDI;
            tdo     = bp_tdo;
         end
      end
   endgenerate
endmodule

// File: rtl/scan_serializer.sv
module scan_serializer #(
   parameter int W      = 8,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 32,
   parameter bit EXT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_count,
   output logic             busy,
   output logic             done,
   input  logic             sel_ext,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [W-1:0]     in_tdi,
   input  logic [W-1:0]     in_tms,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [W-1:0]     out_data,
   output logic             bp_tck,
   output logic             bp_tms,
   output logic             bp_tdi,
   input  logic             bp_tdo,
   output logic             ext_tck,
   output logic             ext_tms,
   output logic             ext_tdi,
   input  logic             ext_tdo
);
   localparam int PAIR_W = 2 * W;

   initial begin
      assert (W >= 2) else $error("scan_serializer: W must be at least 2");
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("scan_serializer: CNT_W must lie in 1..32");
   end

   logic              src_valid, src_pop, snk_push, snk_ready;
   logic [PAIR_W-1:0] src_pair;
   logic [W-1:0]      snk_data;
   logic              tck_i, tms_i, tdi_i, tdo_i;

   scan_fifo #(.DW(PAIR_W), .DEPTH(DEPTH)) u_in_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(in_valid), .wr_data({in_tms, in_tdi}), .wr_ready(in_ready),
      .rd_valid(src_valid), .rd_data(src_pair), .rd_ready(src_pop)
   );

   scan_shift_engine #(.W(W), .CNT_W(CNT_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_count(start_count),
      .src_valid(src_valid), .src_tdi(src_pair[W-1:0]),
      .src_tms(src_pair[PAIR_W-1:W]), .src_pop(src_pop),
      .snk_push(snk_push), .snk_data(snk_data), .snk_ready(snk_ready),
      .tdo_in(tdo_i), .tck(tck_i), .tms(tms_i), .tdi(tdi_i),
      .busy(busy), .done(done)
   );

   scan_fifo #(.DW(W), .DEPTH(DEPTH)) u_out_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(snk_push), .wr_data(snk_data), .wr_ready(snk_ready),
      .rd_valid(out_valid), .rd_data(out_data), .rd_ready(out_ready)
   );

   scan_pin_mux #(.EXT_EN(EXT_EN)) u_pins (
      .sel_ext(sel_ext), .tck(tck_i), .tms(tms_i), .tdi(tdi_i), .tdo(tdo_i),
      .bp_tck(bp_tck), .bp_tms(bp_tms), .bp_tdi(bp_tdi), .bp_tdo(bp_tdo),
      .ext_tck(ext_tck), .ext_tms(ext_tms), .ext_tdi(ext_tdi), .ext_tdo(ext_tdo)
   );
endmodule

// File: rtl/scan_serializer_chk.sv
module scan_serializer_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         busy,
   input logic         done,
   input logic         sel_ext,
   input logic         out_valid,
   input logic         out_ready,
   input logic [W-1:0] out_data,
   input logic         bp_tck,
   input logic         bp_tms,
   input logic         bp_tdi,
   input logic         ext_tck,
   input logic         ext_tms,
   input logic         ext_tdi
);
   p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_no_tck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bp_tck && !ext_tck));

   p_bp_single_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bp_tck |=> !bp_tck);

   p_ext_single_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tck |=> !ext_tck);

   p_bp_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ext && bp_tck) |-> ($stable(bp_tdi) && $stable(bp_tms)));

   p_ext_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ext && ext_tck) |-> ($stable(ext_tdi) && $stable(ext_tms)));

   p_rest_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ext ? (!bp_tck && bp_tms && bp_tdi) : (!ext_tck && ext_tms && ext_tdi));

   p_sel_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel_ext));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind scan_serializer scan_serializer_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sel_ext(sel_ext),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .bp_tck(bp_tck), .bp_tms(bp_tms), .bp_tdi(bp_tdi),
   .ext_tck(ext_tck), .ext_tms(ext_tms), .ext_tdi(ext_tdi)
);

// File: tb/scan_serializer_bench.sv
module scan_serializer_bench;
   localparam int W     = 8;
   localparam int DEPTH = 4;
   localparam int CNT_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             start = 1'b0;
   logic [CNT_W-1:0] start_count = '0;
   logic             busy, done;
   logic             sel_ext = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [W-1:0]     in_tdi = '0, in_tms = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [W-1:0]     out_data;
   logic             bp_tck, bp_tms, bp_tdi, bp_tdo;
   logic             ext_tck, ext_tms, ext_tdi, ext_tdo;

   scan_serializer #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_scan_serializer (
      .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
      .busy(busy), .done(done), .sel_ext(sel_ext),
      .in_valid(in_valid), .in_ready(in_ready), .in_tdi(in_tdi), .in_tms(in_tms),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .bp_tck(bp_tck), .bp_tms(bp_tms), .bp_tdi(bp_tdi), .bp_tdo(bp_tdo),
      .ext_tck(ext_tck), .ext_tms(ext_tms), .ext_tdi(ext_tdi), .ext_tdo(ext_tdo)
   );

   int total = 0;
   int bad   = 0;

   // scan target model
   logic         tdo_bits [0:127];
   logic         tdi_log  [0:127];
   logic         tms_log  [0:127];
   logic [W-1:0] wd_tdi   [0:15];
   logic [W-1:0] wd_tms   [0:15];
   logic [W-1:0] got      [0:15];
   int pulses = 0, tdo_idx = 0, stray = 0, hi_cycles = 0, ngot = 0;

   logic tck_sel, tdi_sel, tms_sel, cur_tdo;
   assign tck_sel = sel_ext ? ext_tck : bp_tck;
   assign tdi_sel = sel_ext ? ext_tdi : bp_tdi;
   assign tms_sel = sel_ext ? ext_tms : bp_tms;
   assign cur_tdo = (tdo_idx < 128) ? tdo_bits[tdo_idx] : 1'b0;
   assign bp_tdo  = sel_ext ? ~cur_tdo : cur_tdo;
   assign ext_tdo = sel_ext ? cur_tdo : ~cur_tdo;

   initial forever begin
      @(posedge tck_sel);
      if (pulses < 128) begin
         tdi_log[pulses] = tdi_sel;
         tms_log[pulses] = tms_sel;
      end
      pulses++;
   end
   initial forever begin
      @(negedge tck_sel);
      tdo_idx++;
   end
   initial forever begin
      @(posedge bp_tck);
      if (sel_ext) stray++;
   end
   initial forever begin
      @(posedge ext_tck);
      if (!sel_ext) stray++;
   end
   initial forever begin
      @(negedge clk);
      if (tck_sel) hi_cycles++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_word(int j, int count);
      logic [W-1:0] v = '0;
      for (int b = 0; b < W; b++)
         if (j * W + b < count) v[b] = tdo_bits[j * W + b];
      return v;
   endfunction

   // gap: hold back the second pair; hold: keep out_ready low for this many cycles
   task automatic run_op(int count, bit ext, bit gap, int hold, bit retry);
      int nw = (count + W - 1) / W;
      int bad_tdi = -1, bad_tms = -1;
      @(negedge clk);
      sel_ext = ext;
      for (int i = 0; i < 16; i++) begin
         wd_tdi[i] = W'($urandom);
         wd_tms[i] = W'($urandom);
      end
      for (int i = 0; i < 128; i++) tdo_bits[i] = 1'($urandom);
      pulses = 0; tdo_idx = 0; stray = 0; hi_cycles = 0; ngot = 0;
      start = 1'b1;
      start_count = CNT_W'(count);
      @(negedge clk);
      start = 1'b0;
      if (count == 0) chk(done && !busy, "R4 zero count done next cycle", {busy, done}, 2'b01);
      else            chk(busy && !done, "R5 busy after start", {busy, done}, 2'b10);
      fork
         begin : feeder
            for (int i = 0; i < nw; i++) begin
               if (gap && i == 1) begin
                  repeat (40) @(negedge clk);
                  chk(pulses == W, "R7 pulses while starved", pulses, W);
                  chk(!tck_sel && busy && !done, "R7 tck parked low", {tck_sel, busy, done}, 3'b010);
               end
               in_valid = 1'b1;
               in_tdi   = wd_tdi[i];
               in_tms   = wd_tms[i];
               while (!in_ready) @(negedge clk);
               @(negedge clk);
               in_valid = 1'b0;
            end
         end
         begin : reader
            int cyc = 0;
            while (ngot < nw) begin
               @(negedge clk);
               cyc++;
               if (hold > 0 && cyc == hold) begin
                  chk(pulses == W * (DEPTH + 1), "R8 pulses at backpressure stop",
                      pulses, W * (DEPTH + 1));
                  chk(!tck_sel && busy, "R8 tck parked low", {tck_sel, busy}, 2'b01);
               end
               out_ready = (cyc >= hold) ? ($urandom % 4 != 0) : 1'b0;
               if (out_valid && out_ready) begin
                  got[ngot] = out_data;
                  ngot++;
               end
            end
            @(negedge clk);
            out_ready = 1'b0;
         end
         begin : restarter
            if (retry) begin
               repeat (3) @(negedge clk);
               start = 1'b1;
               start_count = CNT_W'(3);
               @(negedge clk);
               start = 1'b0;
            end
         end
      join
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(pulses == count, "R4 pulse count", pulses, count);
      chk(hi_cycles == count, "R6 one clock high per pulse", hi_cycles, count);
      for (int k = count - 1; k >= 0; k--) begin
         if (tdi_log[k] !== wd_tdi[k / W][k % W]) bad_tdi = k;
         if (tms_log[k] !== wd_tms[k / W][k % W]) bad_tms = k;
      end
      chk(bad_tdi < 0, "R2 R10 tdi stream lsb first", bad_tdi, -1);
      chk(bad_tms < 0, "R2 R10 tms stream paired", bad_tms, -1);
      for (int j = 0; j < nw; j++)
         chk(got[j] == exp_word(j, count), "R3 captured tdo word", got[j], exp_word(j, count));
      chk(!out_valid, "R3 no extra word", out_valid, 0);
      chk(stray == 0, "R9 no pulses on unselected port", stray, 0);
      chk(done && !busy, "R5 done after op", {busy, done}, 2'b01);
   endtask

   initial begin
      void'($urandom(32'd20517));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
      chk(!bp_tck && !ext_tck, "R1 tck low", {bp_tck, ext_tck}, 0);
      chk(!out_valid && in_ready, "R1 buffers empty", {out_valid, in_ready}, 2'b01);
      chk(ext_tms && ext_tdi, "R9 external port rests high", {ext_tms, ext_tdi}, 2'b11);

      run_op(20, 1'b0, 1'b0, 0, 1'b0);
      run_op(0, 1'b0, 1'b0, 0, 1'b0);
      run_op(16, 1'b0, 1'b1, 0, 1'b0);
      run_op(64, 1'b0, 1'b0, 120, 1'b0);
      run_op(21, 1'b1, 1'b0, 0, 1'b1);   // R5 start while busy is ignored
      chk(bp_tms && bp_tdi && !bp_tck, "R9 backplane rests while external selected",
          {bp_tck, bp_tms, bp_tdi}, 3'b011);
      repeat (5) @(negedge clk);
      chk(done && !busy, "R5 done is sticky", {busy, done}, 2'b01);
      run_op(W, 1'b0, 1'b0, 0, 1'b0);

      for (int n = 0; n < 14; n++)
         run_op(1 + int'($urandom % 60), 1'($urandom), 1'b0, 0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", pulses, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule